// File: doc/BRIEF.md
# IrDA SIR Pulse Encoder/Decoder

This block sits between a UART core and an infrared transceiver. On the transmit side it turns the UART's NRZ serial bit into a return-to-zero-inverted light pulse stream. Every zero bit becomes a short active-high pulse. A one bit leaves the output low, which means no light. In normal mode the pulse width is measured in periods of the 16x baud enable. In low-power mode it is measured in periods of a low-power tick, which an internal divider derives from the clock.

On the receive side the active-low detector input passes through a synchronizer. A low level is only a candidate pulse: it is accepted if the input is still low one low-power tick period after it was first seen. An accepted pulse is stretched into a zero on the NRZ output that is almost a full bit wide, so an ordinary UART receiver can sample it at mid-bit. A test path can feed the encoder output back into the decoder. With SIR disabled, the plain serial input goes straight to the NRZ output and the emitter stays dark.

Top module: `sir_codec`

## Requirements
- R1: While SIR is enabled, a zero on `txd` produces one high pulse on `ir_out`; the pulse starts in the cycle after the first `baud16_tick` of the bit. A one on `txd` produces no pulse, and `ir_out` stays low.
- R2: In normal mode (`lowpwr_en`=0) each pulse lasts exactly 3 `baud16_tick` periods. With ticks every P clocks, that is 3·P clock cycles.
- R3: In low-power mode (`lowpwr_en`=1) each pulse lasts exactly 3 low-power tick periods, which is 3·D clock cycles for divisor D. The low-power divider restarts when the pulse starts.
- R4: A divisor value of 0 behaves like 1. A low-power pulse is then 3 cycles long, and a detector pulse of 2 cycles is accepted while a detector pulse of 1 cycle is rejected.
- R5: In either mode, a low on `ir_in_n` lasting D+1 clock cycles or more is accepted as a zero. A low lasting D cycles or fewer is ignored and leaves `rxd` high. D is the effective divisor; the input passes through a 2-flop synchronizer first.
- R6: After an accepted pulse, `rxd` is held low. It returns high on the 15th `baud16_tick` counted from the cycle the low was first seen, so a zero lasts between 14 and 15 tick periods minus D.
- R7: When `lb_en` and `sir_test` are both 1, the decoder sees the inverted encoder output instead of `ir_in_n`. At mid-bit, `rxd` then equals the transmitted bit, and `ir_in_n` has no effect.
- R8: With `sir_en`=0, `ir_out` stays low for any `txd`, and `rxd` equals `ser_in`.
- R9: After reset, `ir_out` is 0 and `rxd` is 1 while the detector input idles high.
- R10: Consecutive zero bits each produce their own pulse, one bit period (16 ticks) apart, with no `txd` edge needed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| sir_en | input | 1 | Enables the infrared encoder and decoder |
| lowpwr_en | input | 1 | Selects the low-power pulse width |
| lb_en | input | 1 | Loopback enable |
| sir_test | input | 1 | Infrared test select; with `lb_en` routes encoder to decoder |
| lp_div | input | DIV_W | Low-power divisor in clock cycles (0 acts as 1) |
| baud16_tick | input | 1 | One-cycle enable at 16x the baud rate |
| txd | input | 1 | NRZ transmit bit from the UART |
| ir_out | output | 1 | Active-high emitter pulse |
| ir_in_n | input | 1 | Active-low detector input, asynchronous |
| ser_in | input | 1 | Plain serial input used when SIR is off |
| rxd | output | 1 | NRZ receive bit to the UART |

## Verification
The bench measures the exact width of every emitter pulse in both modes and with a zero divisor. A counter that is off by one tick, or a divider that is not restarted at the pulse start, shows up as a width of 2 or 4 periods, or as a low-power width that wanders. It drives detector pulses exactly one cycle either side of the acceptance threshold. A decoder that qualifies one cycle early or late would then accept the short pulse or drop the long one. Runs of zeros check that a pulse is re-armed at each bit boundary without a `txd` edge. The loopback run holds the external detector low, so a decoder that ignored the test path would show a stuck zero during one bits.

// File: rtl/sir_pkg.sv
`timescale 1ns/1ps
package sir_pkg;

    localparam int SIR_OSR       = 16;
    localparam int SIR_DIV_W     = 8;
    localparam int SIR_SYNC_N    = 2;
    localparam int SIR_PULSE_TCK = 3;

    typedef enum logic [1:0] {
        DEC_IDLE = 2'd0,
        DEC_QUAL = 2'd1,
        DEC_HOLD = 2'd2
    } dec_state_e;

endpackage

// File: rtl/sir_lp_div.sv
`timescale 1ns/1ps
module sir_lp_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] last;

    always_comb begin
        // a zero divisor behaves as one: tick every cycle
        last  = (div == '0) ? '0 : div - DIV_W'(1);
        tick  = (cnt_q >= last);
        if (restart || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sir_enc.sv
`timescale 1ns/1ps
module sir_enc
    import sir_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lowpwr,
    input  logic txd,
    input  logic b16_tick,
    input  logic lp_tick,
    output logic pulse,
    output logic fire
);

    localparam int              PH_W    = $clog2(OSR);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
    localparam logic [1:0]      W_LAST  = 2'(SIR_PULSE_TCK - 1);

    typedef struct packed {
        logic            txd_q;
        logic            arm;
        logic [PH_W-1:0] phase;
        logic            active;
        logic [1:0]      wcnt;
    } enc_s;

    localparam enc_s ENC_RST = '{txd_q: 1'b1, arm: 1'b0, phase: '0,
                                 active: 1'b0, wcnt: 2'b00};

    enc_s            d, q;
    logic            txd_chg;
    logic            arm_eff;
    logic            src_tick;
    logic [PH_W-1:0] ph_eff;

    always_comb begin
        d        = q;
        fire     = 1'b0;
        txd_chg  = (txd != q.txd_q);
        // a bit boundary is either a txd change or a phase wrap
        arm_eff  = q.arm | txd_chg;
        ph_eff   = txd_chg ? '0 : q.phase;
        src_tick = lowpwr ? lp_tick : b16_tick;

        if (!en) begin
            d       = ENC_RST;
            d.txd_q = txd;
        end else begin
            d.txd_q = txd;
            if (b16_tick) begin
                fire    = arm_eff & ~txd;
                d.arm   = (ph_eff == PH_LAST);
                d.phase = (ph_eff == PH_LAST) ? '0 : ph_eff + PH_W'(1);
            end else begin
                d.arm   = arm_eff;
                d.phase = ph_eff;
            end

            if (fire) begin
                d.active = 1'b1;
                d.wcnt   = 2'b00;
            end else if (q.active && src_tick) begin
                if (q.wcnt == W_LAST) begin
                    d.active = 1'b0;
                end else begin
                    d.wcnt = q.wcnt + 2'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= ENC_RST;
        end else begin
            q <= d;
        end
    end

    assign pulse = q.active;

endmodule

// File: rtl/sir_dec.sv
`timescale 1ns/1ps
module sir_dec
    import sir_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int OSR   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             din_n,
    input  logic             b16_tick,
    input  logic [DIV_W-1:0] div,
    output logic             nrz
);

    localparam int              PH_W      = $clog2(OSR);
    localparam logic [PH_W-1:0] HOLD_LAST = PH_W'(OSR - 2);

    typedef struct packed {
        dec_state_e       st;
        logic [DIV_W-1:0] qcnt;
        logic [PH_W-1:0]  hcnt;
        logic             nrz;
    } dec_s;

    localparam dec_s DEC_RST = '{st: DEC_IDLE, qcnt: '0, hcnt: '0, nrz: 1'b1};

    dec_s             d, q;
    logic [DIV_W-1:0] last;

    always_comb begin
        d    = q;
        last = (div == '0) ? '0 : div - DIV_W'(1);

        if (!en) begin
            d = DEC_RST;
        end else begin
            case (q.st)
                DEC_IDLE: begin
                    if (!din_n) begin
                        d.st   = DEC_QUAL;
                        d.qcnt = '0;
                        d.hcnt = '0;
                    end
                end
                DEC_QUAL: begin
                    if (b16_tick) begin
                        d.hcnt = q.hcnt + PH_W'(1);
                    end
                    if (din_n) begin
                        d.st = DEC_IDLE;
                    end else if (q.qcnt >= last) begin
                        d.st  = DEC_HOLD;
                        d.nrz = 1'b0;
                    end else begin
                        d.qcnt = q.qcnt + DIV_W'(1);
                    end
                end
                DEC_HOLD: begin
                    if (b16_tick) begin
                        if (q.hcnt >= HOLD_LAST) begin
                            d.st  = DEC_IDLE;
                            d.nrz = 1'b1;
                        end else begin
                            d.hcnt = q.hcnt + PH_W'(1);
                        end
                    end
                end
                default: d = DEC_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= DEC_RST;
        end else begin
            q <= d;
        end
    end

    assign nrz = q.nrz;

endmodule

// File: rtl/sir_codec.sv
`timescale 1ns/1ps
module sir_codec
    import sir_pkg::*;
#(
    parameter int DIV_W  = SIR_DIV_W,
    parameter int OSR    = SIR_OSR,
    parameter int SYNC_N = SIR_SYNC_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sir_en,
    input  logic             lowpwr_en,
    input  logic             lb_en,
    input  logic             sir_test,
    input  logic [DIV_W-1:0] lp_div,
    input  logic             baud16_tick,
    input  logic             txd,
    output logic             ir_out,
    input  logic             ir_in_n,
    input  logic             ser_in,
    output logic             rxd
);

    logic              lp_tick;
    logic              enc_pulse;
    logic              enc_fire;
    logic              lp_restart;
    logic              dec_in;
    logic              dec_nrz;
    logic              loop_sel;
    logic [SYNC_N-1:0] sync_d, sync_q;

    generate
        if (SYNC_N > 1) begin : g_sync_chain
            always_comb sync_d = {sync_q[SYNC_N-2:0], ir_in_n};
        end else begin : g_sync_single
            always_comb sync_d = ir_in_n;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    always_comb begin
        lp_restart = enc_fire & lowpwr_en;
        loop_sel   = lb_en & sir_test;
        dec_in     = loop_sel ? ~enc_pulse : sync_q[SYNC_N-1];
        rxd        = sir_en ? dec_nrz : ser_in;
        ir_out     = enc_pulse;
    end

    sir_lp_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (lp_div),
        .restart (lp_restart),
        .tick    (lp_tick)
    );

    sir_enc #(.OSR(OSR)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (sir_en),
        .lowpwr   (lowpwr_en),
        .txd      (txd),
        .b16_tick (baud16_tick),
        .lp_tick  (lp_tick),
        .pulse    (enc_pulse),
        .fire     (enc_fire)
    );

    sir_dec #(.DIV_W(DIV_W), .OSR(OSR)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (sir_en),
        .din_n    (dec_in),
        .b16_tick (baud16_tick),
        .div      (lp_div),
        .nrz      (dec_nrz)
    );

endmodule

// File: rtl/sir_codec_chk.sv
`timescale 1ns/1ps
module sir_codec_chk (
    input logic clk,
    input logic rst_n,
    input logic sir_en,
    input logic lowpwr_en,
    input logic txd,
    input logic baud16_tick,
    input logic ir_out,
    input logic dec_in,
    input logic dec_nrz
);

    // R1: a pulse begins only right after a baud tick that saw a zero
    p_rise_on_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_out) |-> ($past(baud16_tick) && !$past(txd)));

    // R2: in normal mode a pulse ends only on a baud tick
    p_normal_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ir_out) && !$past(lowpwr_en) && $past(sir_en)) |-> $past(baud16_tick));

    // R8: disabled encoder keeps the emitter dark
    p_dark_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sir_en |=> !ir_out);

    // R5: a zero is only produced after the decoder input was low
    p_accept_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dec_nrz) |-> !$past(dec_in));

    // R6: the stretched zero ends only on a baud tick or on disable
    p_release_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_nrz) |-> ($past(baud16_tick) || !$past(sir_en)));

endmodule

bind sir_codec sir_codec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sir_en      (sir_en),
    .lowpwr_en   (lowpwr_en),
    .txd         (txd),
    .baud16_tick (baud16_tick),
    .ir_out      (ir_out),
    .dec_in      (dec_in),
    .dec_nrz     (dec_nrz)
);

// File: tb/sir_codec_tb.sv
`timescale 1ns/1ps
module sir_codec_tb;

    localparam int B = 8;  // clocks per baud16 tick

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sir_en = 1'b1;
    logic       lowpwr_en = 1'b0;
    logic       lb_en = 1'b0;
    logic       sir_test = 1'b0;
    logic [7:0] lp_div = 8'd4;
    logic       b16 = 1'b0;
    logic       txd = 1'b1;
    logic       ir_out;
    logic       ir_in_n = 1'b1;
    logic       ser_in = 1'b1;
    logic       rxd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int bc       = 0;
    int run      = 0;
    int n_pulses = 0;
    int mon_e;
    string mon_t;
    int    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    sir_codec u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sir_en      (sir_en),
        .lowpwr_en   (lowpwr_en),
        .lb_en       (lb_en),
        .sir_test    (sir_test),
        .lp_div      (lp_div),
        .baud16_tick (b16),
        .txd         (txd),
        .ir_out      (ir_out),
        .ir_in_n     (ir_in_n),
        .ser_in      (ser_in),
        .rxd         (rxd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_tb();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // baud16 enable, updated away from the active edge
    always @(negedge clk) begin
        if (bc == B - 1) begin
            bc  <= 0;
            b16 <= 1'b1;
        end else begin
            bc  <= bc + 1;
            b16 <= 1'b0;
        end
    end

    // monitor: measures every emitter pulse and pops the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (ir_out) begin
                run++;
            end else if (run > 0) begin
                n_pulses++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1/R8 unexpected pulse", run, 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    mon_t = tag_q.pop_front();
                    chk(run == mon_e, mon_t, run, mon_e);
                end
                run = 0;
            end
        end
    end

    task automatic wait_tick();
        do @(posedge clk); while (!b16);
    endtask

    // driver: one bit per 16 ticks, expected widths go to the scoreboard
    task automatic send_bits(input logic [15:0] bits, input int n, input int w,
                             input bit lb_chk, input string tag);
        for (int i = 0; i < n; i++) begin
            wait_tick();
            @(negedge clk);
            txd = bits[i];
            if (!bits[i] && w > 0) begin
                exp_q.push_back(w);
                tag_q.push_back(tag);
            end
            repeat (8) wait_tick();
            if (lb_chk) begin
                @(negedge clk);
                chk(rxd == bits[i], "R7 loopback mid-bit value", int'(rxd), int'(bits[i]));
            end
            repeat (7) wait_tick();
        end
        wait_tick();
        @(negedge clk);
        txd = 1'b1;
        repeat (20) wait_tick();
    endtask

    // detector pulse of L cycles; returns rxd low count over the window
    task automatic dec_pulse(input int L, input bit acc, input string tag);
        int low = 0;
        for (int c = 0; c < 180; c++) begin
            @(negedge clk);
            ir_in_n = (c < L) ? 1'b0 : 1'b1;
            if (!rxd) low++;
        end
        if (acc) begin
            chk(low >= 14 * B - 8 && low <= 15 * B, tag, low, 15 * B);
        end else begin
            chk(low == 0, tag, low, 0);
        end
        repeat (60) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_tb();
    end

    initial begin
        int p0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(ir_out == 1'b0, "R9 ir_out after reset", int'(ir_out), 0);
        chk(rxd == 1'b1, "R9 rxd after reset", int'(rxd), 1);

        // R1, R2, R10: normal mode, including runs of zeros
        send_bits(16'b1011_0010, 8, 3 * B, 1'b0, "R2 normal width");
        send_bits(16'b0000_0000, 4, 3 * B, 1'b0, "R10 back-to-back zero width");

        // R3: low-power width, divisor 4
        lowpwr_en = 1'b1;
        lp_div    = 8'd4;
        send_bits(16'b0110_0100, 8, 12, 1'b0, "R3 low-power width");

        // R4: divisor zero acts as one
        lp_div = 8'd0;
        send_bits(16'b0000_0010, 3, 3, 1'b0, "R4 zero divisor width");
        lowpwr_en = 1'b0;
        lp_div    = 8'd4;

        // R7: loopback with the external detector held low
        ir_in_n  = 1'b0;
        lb_en    = 1'b1;
        sir_test = 1'b1;
        send_bits(16'b1100_1001, 8, 3 * B, 1'b1, "R7 loopback width");
        ir_in_n = 1'b1;
        repeat (20) @(negedge clk);
        lb_en    = 1'b0;
        sir_test = 1'b0;
        repeat (20) @(negedge clk);

        // R5, R6: acceptance threshold in both modes
        dec_pulse(5, 1'b1, "R5/R6 normal D+1 accepted");
        dec_pulse(4, 1'b0, "R5 normal D rejected");
        lowpwr_en = 1'b1;
        dec_pulse(4, 1'b0, "R5 low-power D rejected");
        dec_pulse(5, 1'b1, "R5/R6 low-power D+1 accepted");
        lp_div = 8'd0;
        dec_pulse(1, 1'b0, "R4 zero divisor 1 cycle rejected");
        dec_pulse(2, 1'b1, "R4 zero divisor 2 cycles accepted");
        lowpwr_en = 1'b0;
        lp_div    = 8'd4;

        // R8: SIR disabled
        sir_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            ser_in = k[0];
            @(negedge clk);
            chk(rxd == ser_in, "R8 rxd follows ser_in", int'(rxd), int'(ser_in));
        end
        ser_in  = 1'b1;
        ir_in_n = 1'b0;
        repeat (20) @(negedge clk);
        chk(rxd == 1'b1, "R8 detector ignored when off", int'(rxd), 1);
        ir_in_n = 1'b1;
        p0 = n_pulses;
        send_bits(16'b0000_0000, 3, 0, 1'b0, "R8");
        chk(n_pulses == p0, "R8 no pulses when off", n_pulses - p0, 0);
        sir_en = 1'b1;
        repeat (20) @(negedge clk);

        chk(exp_q.size() == 0, "R1/R10 every zero produced a pulse", exp_q.size(), 0);
        finish_tb();
    end

endmodule